// File: doc/BRIEF.md
# Redundant Bus Selector with Per-Terminal Swap

This block picks which of two redundant serial buses, A or B, carries each transfer that a bus controller issues. Each transfer names a remote terminal (RT) by a 5-bit address and carries a bus-select bit. The block keeps a 32-bit swap register with one bit per RT address. The bus actually used is the bus-select bit XORed with that terminal's swap bit. Setting a terminal's swap bit therefore moves all of its traffic to the other bus, and no descriptor has to be edited.

A two-state controller handles each transfer. In `ST_IDLE` the block waits for a start strobe. The transition `start` captures the chosen bus, the RT address and the store-bus flag, then enters `ST_BUSY`. In `ST_BUSY` the captured bus drives `active_bus`. The transition `done` returns the controller to `ST_IDLE`. If the store-bus flag was set at start, the same `done` also rewrites the terminal's swap bit from the outcome: 0 after a success on bus A, 1 after a success on bus B, and the inverted value after a failure. The next transfer to that terminal then either stays on the bus that worked or moves away from the bus that failed. Software can read the swap register and overwrite it as a whole.

Top module: `redundant_bus_sel`

## Requirements
- R1: After reset the swap register is all zeros, the controller is in `ST_IDLE`, and `active_bus` is 0 (bus A).
- R2: `bus_pick` is combinational and equals `sel_bit` XOR swap bit [`rt_addr`], with 0 meaning bus A and 1 meaning bus B.
- R3: A set swap bit inverts the meaning of `sel_bit` for its own RT address only. Other addresses keep the plain meaning.
- R4: `xfer_start` in `ST_IDLE` captures `bus_pick`, `rt_addr` and `store_en` and enters `ST_BUSY`. `active_bus` shows the captured bus from the cycle after the start edge.
- R5: While in `ST_BUSY`, a further `xfer_start`, changes to `rt_addr`/`sel_bit`, and writes to the swap register leave the captured bus and address unchanged.
- R6: `xfer_done` with `xfer_ok`=1 in `ST_BUSY`, with store-bus captured, writes the captured bus value into the captured RT's swap bit (A gives 0, B gives 1). The write is visible on `sw_rdata` after that edge.
- R7: `xfer_done` with `xfer_ok`=0 in `ST_BUSY`, with store-bus captured, writes the inverse of the captured bus value into that swap bit.
- R8: The swap register does not change on `xfer_done` when store-bus was not captured, or when the controller is in `ST_IDLE`.
- R9: `sw_we` loads all 32 bits from `sw_wdata` at the clock edge, and `sw_rdata` always shows the register.
- R10: When a software write and a store-bus update land on the same edge, the updated bit takes the hardware value and every other bit takes `sw_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_addr | input | 5 | Remote terminal address of the transfer |
| sel_bit | input | 1 | Descriptor bus-select bit |
| store_en | input | 1 | Store-bus enable for the transfer |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_done | input | 1 | Transfer complete strobe |
| xfer_ok | input | 1 | Transfer outcome, 1 = success |
| sw_we | input | 1 | Software write enable for the swap register |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current swap register |
| bus_pick | output | 1 | Combinational bus choice for the current inputs |
| active_bus | output | 1 | Bus captured for the transfer in progress |

## Verification
`bus_pick` has no register in its path, so the bench sets the inputs after a falling edge and samples 1 ns later within the same cycle. `active_bus` passes through one register and is sampled at the falling edge that follows the start edge. A swap-bit update or a software write goes through one register as well, so `sw_rdata` is read at the falling edge after the `xfer_done` or `sw_we` edge. The collision case puts both strobes on a single edge and reads the merged register in the next half cycle.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    typedef enum logic {
        BUS_A = 1'b0,
        BUS_B = 1'b1
    } bus_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } xfer_st_e;
endpackage

// File: rtl/bus_pick_xor.sv
module bus_pick_xor #(
    parameter int ADDR_W = 5,
    localparam int NUM_RT = 1 << ADDR_W
) (
    input  logic [NUM_RT-1:0] swap_vec,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    output logic              pick
);
    // the swap bit flips the meaning of the descriptor bit
    always_comb pick = swap_vec[addr] ^ sel;
endmodule

// File: rtl/swap_bank.sv
module swap_bank #(
    parameter int ADDR_W = 5,
    localparam int NUM_RT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [NUM_RT-1:0] sw_wdata,
    input  logic              hw_we,
    input  logic [ADDR_W-1:0] hw_idx,
    input  logic              hw_val,
    output logic [NUM_RT-1:0] swap_q
);
    for (genvar g = 0; g < NUM_RT; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                swap_q[g] <= 1'b0;
            else if (hw_we && hw_idx == ADDR_W'(g))
                swap_q[g] <= hw_val;     // hardware wins on collision
            else if (sw_we)
                swap_q[g] <= sw_wdata[g];
        end
    end

    p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |=> swap_q[$past(hw_idx)] == $past(hw_val));

    p_sw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !hw_we) |=> swap_q == $past(sw_wdata));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !hw_we) |=> $stable(swap_q));
endmodule

// File: rtl/bus_xfer_fsm.sv
module bus_xfer_fsm
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    input  logic              ok,
    input  logic              pick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              store_en,
    output logic              act_bus,
    output logic              upd_we,
    output logic [ADDR_W-1:0] upd_idx,
    output logic              upd_val
);
    xfer_st_e          state_q, state_d;
    bus_e              bus_q;
    logic [ADDR_W-1:0] idx_q;
    logic              store_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_BUSY;
            ST_BUSY: if (done)  state_d = ST_IDLE;
        endcase
    end

    // state register and capture of the transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bus_q   <= BUS_A;
            idx_q   <= '0;
            store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                bus_q   <= bus_e'(pick);
                idx_q   <= addr;
                store_q <= store_en;
            end
        end
    end

    // outputs
    always_comb begin
        act_bus = bus_q;
        upd_idx = idx_q;
        upd_we  = 1'b0;
        upd_val = 1'b0;
        unique case (state_q)
            ST_IDLE: upd_we = 1'b0;
            ST_BUSY: begin
                upd_we  = done && store_q;
                upd_val = ok ? bus_q : ~bus_q;
            end
        endcase
    end

    p_start_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_BUSY && act_bus == $past(pick)));

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !done) |=> ($stable(act_bus) && $stable(upd_idx)));

    p_idle_no_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !upd_we);
endmodule

// File: rtl/redundant_bus_sel.sv
module redundant_bus_sel #(
    parameter int ADDR_W = 5,
    localparam int NUM_RT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              sel_bit,
    input  logic              store_en,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic              xfer_ok,
    input  logic              sw_we,
    input  logic [NUM_RT-1:0] sw_wdata,
    output logic [NUM_RT-1:0] sw_rdata,
    output logic              bus_pick,
    output logic              active_bus
);
    logic              upd_we;
    logic [ADDR_W-1:0] upd_idx;
    logic              upd_val;
    logic [NUM_RT-1:0] swap_q;

    bus_pick_xor #(.ADDR_W(ADDR_W)) u_pick (
        .swap_vec (swap_q),
        .addr     (rt_addr),
        .sel      (sel_bit),
        .pick     (bus_pick)
    );

    bus_xfer_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .done     (xfer_done),
        .ok       (xfer_ok),
        .pick     (bus_pick),
        .addr     (rt_addr),
        .store_en (store_en),
        .act_bus  (active_bus),
        .upd_we   (upd_we),
        .upd_idx  (upd_idx),
        .upd_val  (upd_val)
    );

    swap_bank #(.ADDR_W(ADDR_W)) u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .hw_we    (upd_we),
        .hw_idx   (upd_idx),
        .hw_val   (upd_val),
        .swap_q   (swap_q)
    );

    assign sw_rdata = swap_q;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (sw_rdata == '0 && active_bus == 1'b0));
endmodule

// File: tb/tb_redundant_bus_sel.sv
`timescale 1ns/1ps
module tb_redundant_bus_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rt_addr = '0;
    logic        sel_bit = 1'b0, store_en = 1'b0, xfer_start = 1'b0;
    logic        xfer_done = 1'b0, xfer_ok = 1'b0, sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        bus_pick, active_bus;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    redundant_bus_sel dut (
        .clk(clk), .rst_n(rst_n), .rt_addr(rt_addr), .sel_bit(sel_bit),
        .store_en(store_en), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .xfer_ok(xfer_ok), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .bus_pick(bus_pick), .active_bus(active_bus)
    );

    // vectors: preset, rt, sel, store, ok -> expected bus, expected swap bit
    localparam int NV = 8;
    localparam logic [31:0] V_PRE [NV] = '{32'h0, 32'h0, 32'h80, 32'h80,
                                          32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0010_0000};
    localparam logic [4:0]  V_RT  [NV] = '{5'd3, 5'd3, 5'd7, 5'd7, 5'd31, 5'd0, 5'd12, 5'd20};
    localparam logic        V_SEL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic        V_ST  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic        V_OK  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic        V_BUS [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic        V_BIT [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [31:0] d);
        sw_we = 1'b1; sw_wdata = d;
        @(posedge clk); @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic pulse_start();
        xfer_start = 1'b1;
        @(posedge clk); @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic pulse_done(input logic ok);
        xfer_done = 1'b1; xfer_ok = ok;
        @(posedge clk); @(negedge clk);
        xfer_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1 swap reset", sw_rdata, 32'h0);
        chk("R1 bus reset", active_bus, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 swap after release", sw_rdata, 32'h0);

        // table walk: R2, R4, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp_reg;
            sw_write(V_PRE[i]);
            rt_addr = V_RT[i]; sel_bit = V_SEL[i]; store_en = V_ST[i];
            #1;
            chk("R2 pick", bus_pick, V_BUS[i]);
            @(negedge clk);
            pulse_start();
            chk("R4 active bus", active_bus, V_BUS[i]);
            pulse_done(V_OK[i]);
            exp_reg = V_PRE[i];
            exp_reg[V_RT[i]] = V_BIT[i];
            chk(V_ST[i] ? (V_OK[i] ? "R6 swap update" : "R7 swap update") : "R8 no store",
                sw_rdata, exp_reg);
        end

        // R3: only the owning RT is inverted
        sw_write(32'h0000_0020);
        sel_bit = 1'b0; rt_addr = 5'd5; #1;
        chk("R3 inverted rt", bus_pick, 1'b1);
        rt_addr = 5'd6; #1;
        chk("R3 other rt", bus_pick, 1'b0);
        sel_bit = 1'b1; #1;
        chk("R3 other rt sel1", bus_pick, 1'b1);
        @(negedge clk);

        // R5: captured context holds during the transfer
        sw_write(32'h0);
        rt_addr = 5'd2; sel_bit = 1'b0; store_en = 1'b1;
        pulse_start();
        chk("R5 captured A", active_bus, 1'b0);
        sw_write(32'hFFFF_FFFF);
        rt_addr = 5'd9; sel_bit = 1'b1; store_en = 1'b0;
        pulse_start();
        chk("R5 second start ignored", active_bus, 1'b0);
        pulse_done(1'b1);
        chk("R5 update uses captured bus/rt", sw_rdata, 32'hFFFF_FFFB);

        // R8: done while idle does nothing
        store_en = 1'b1;
        pulse_done(1'b0);
        chk("R8 done in idle", sw_rdata, 32'hFFFF_FFFB);

        // R9: full software load
        sw_write(32'hA5C3_1E0F);
        chk("R9 software load", sw_rdata, 32'hA5C3_1E0F);

        // R10: collision, hardware bit wins
        rt_addr = 5'd9; sel_bit = 1'b1; store_en = 1'b1;
        sw_write(32'h0);
        pulse_start();
        sw_we = 1'b1; sw_wdata = 32'h0000_F000;
        xfer_done = 1'b1; xfer_ok = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_we = 1'b0; xfer_done = 1'b0;
        chk("R10 collision merge", sw_rdata, 32'h0000_F200);

        // R1: reset in the middle of a transfer
        rt_addr = 5'd1; sel_bit = 1'b1;
        pulse_start();
        rst_n = 1'b0; #1;
        chk("R1 async reset swap", sw_rdata, 32'h0);
        chk("R1 async reset bus", active_bus, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule